// File: doc/BRIEF.md
# Dual-set baud rate selector

This block turns one fixed reference clock into four independent 16x-oversample tick strobes, one for the receiver and one for the transmitter of each of two serial channels. Each channel owns an 8-bit clock-select register. Its high nibble chooses the receive rate and its low nibble chooses the transmit rate. One global bit in an auxiliary control register switches all four selections between two rate sets. A tick is a single-cycle pulse that repeats every `divisor` clock cycles. The divisor comes from a constant table that is computed at elaboration from the `REF_HZ` parameter as round(REF_HZ / (16 x baud)).

Each tick output is produced by its own small state machine. The machine has two states:

- **TG_RELOAD**: the counter is about to be loaded. No tick is emitted in this state.
- **TG_RUN**: the counter counts down.

The transitions are:

- **load** (TG_RELOAD to TG_RUN): the counter is set to divisor-1.
- **count** (TG_RUN to TG_RUN, counter above zero): the counter decrements.
- **wrap** (TG_RUN to TG_RUN, counter at zero): the tick is emitted and the counter is set back to divisor-1.
- **restart** (any state to TG_RELOAD): a write hits a register that feeds this generator. Restart takes priority over the other transitions.

Because of restart, a new rate takes effect at once and never waits out a long stale count. Selection codes 13 to 15 stand for clock sources that are not provided here, and they fall back to 4800 baud.

Top module: `dual_set_baud_sel`

## Requirements
- R1: While reset is low, all four ticks are 0, both clock-select registers are 0 and set 0 is selected. After reset is released, each generator loads the set-0 code-0 divisor (4608 at 3.6864 MHz). The first tick comes 4608 cycles after the release edge.
- R2: For channel A (write address 0) and channel B (write address 1), bits [7:4] of the channel's clock-select register pick the receive tick rate and bits [3:0] pick the transmit tick rate. The two nibbles are independent.
- R3: Bit 7 of the auxiliary register (write address 4) selects the rate set: 0 gives set 0 and 1 gives set 1. The other bits of that register have no effect.
- R4: In set 0, codes 0 to 12 give 50, 110, 134.5, 200, 300, 600, 1200, 1050, 2400, 4800, 7200, 9600 and 38400 baud. At 3.6864 MHz the divisors are 4608, 2095, 1713, 1152, 768, 384, 192, 219, 96, 48, 32, 24 and 6.
- R5: In set 1, codes 0 to 12 give 75, 110, 134.5, 150, 300, 600, 1200, 2000, 2400, 4800, 1800, 9600 and 19200 baud. At 3.6864 MHz the divisors are 3072, 2095, 1713, 1536, 768, 384, 192, 115, 96, 48, 128, 24 and 12.
- R6: Codes 13, 14 and 15 select 4800 baud (divisor 48) in both sets.
- R7: While no restart occurs, a tick is high for exactly one cycle and repeats every divisor cycles.
- R8: A write to a channel's clock-select register restarts that channel's two generators. Each one goes to TG_RELOAD on the write edge, loads on the next edge, and first ticks exactly divisor cycles after the write edge. The other channel's ticks keep their phase.
- R9: A write to the auxiliary register restarts all four generators with the same timing as R8.
- R10: A write to any address other than 0, 1 or 4 changes no register, restarts no generator and leaves every tick phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, frequency given by REF_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_addr | input | 3 | Write address: 0 selects channel A clock-select, 1 selects channel B clock-select, 4 selects the auxiliary register |
| wr_data | input | 8 | Write data |
| tick_rx_a | output | 1 | Channel A receive 16x tick |
| tick_tx_a | output | 1 | Channel A transmit 16x tick |
| tick_rx_b | output | 1 | Channel B receive 16x tick |
| tick_tx_b | output | 1 | Channel B transmit 16x tick |

## Verification
A wrong table entry, a wrong nibble selection or a wrong set bit appears as a tick period that differs from the expected divisor. This shows up within one period of the next restart. A counter that reloads one cycle early or late, or that misses a restart, shifts the first tick after a write by a fixed number of cycles, so it is caught on that first pulse. A restart leaking to the wrong channel, or a decode hit on an ignored address, breaks the phase of a tick that should have run on undisturbed. That break shows within one period of that tick.

// File: rtl/baud_sel_pkg.sv
package baud_sel_pkg;

    // Tick generator states
    typedef enum logic [0:0] {
        TG_RELOAD = 1'b0,
        TG_RUN    = 1'b1
    } tick_state_e;

    localparam int unsigned OVERSAMPLE  = 16;
    localparam int unsigned TABLE_SIZE  = 32;
    localparam int          AUX_SET_BIT = 7;

    localparam logic [2:0] ADDR_CSR_A = 3'd0;
    localparam logic [2:0] ADDR_CSR_B = 3'd1;
    localparam logic [2:0] ADDR_AUX   = 3'd4;

    // Twice the baud rate, so that 134.5 stays an integer.
    // Index bit 4 is the set, bits 3:0 the code.
    function automatic int unsigned baud_x2(input int unsigned idx);
        int unsigned r;
        case (idx)
            0:  r = 100;
            1:  r = 220;
            2:  r = 269;
            3:  r = 400;
            4:  r = 600;
            5:  r = 1200;
            6:  r = 2400;
            7:  r = 2100;
            8:  r = 4800;
            9:  r = 9600;
            10: r = 14400;
            11: r = 19200;
            12: r = 76800;
            16: r = 150;
            17: r = 220;
            18: r = 269;
            19: r = 300;
            20: r = 600;
            21: r = 1200;
            22: r = 2400;
            23: r = 4000;
            24: r = 4800;
            25: r = 9600;
            26: r = 3600;
            27: r = 19200;
            28: r = 38400;
            default: r = 9600;  // 4800 baud fallback
        endcase
        return r;
    endfunction

    // Nearest-integer clock divisor for one tick period.
    function automatic int unsigned rate_divisor(input int unsigned ref_hz,
                                                 input int unsigned idx);
        int unsigned b2;
        b2 = baud_x2(idx);
        return (2 * ref_hz + (OVERSAMPLE * b2) / 2) / (OVERSAMPLE * b2);
    endfunction

endpackage

// File: rtl/baud_div_lut.sv
module baud_div_lut
    import baud_sel_pkg::*;
#(
    parameter int unsigned REF_HZ = 3686400,
    parameter int          CNT_W  = 13
) (
    input  logic             set_i,
    input  logic [3:0]       code_i,
    output logic [CNT_W-1:0] div_o
);

    logic [CNT_W-1:0] tab [TABLE_SIZE];

    for (genvar i = 0; i < TABLE_SIZE; i++) begin : g_entry
        localparam int unsigned DIV_I = rate_divisor(REF_HZ, i);
        assign tab[i] = CNT_W'(DIV_I);
    end

    assign div_o = tab[{set_i, code_i}];

endmodule

// File: rtl/baud_sel_regs.sv
module baud_sel_regs
    import baud_sel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [2:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] csr_a_o,
    output logic [7:0] csr_b_o,
    output logic       set_o,
    output logic [1:0] reload_o
);

    logic hit_a, hit_b, hit_aux;

    always_comb begin
        hit_a    = wr_en_i && (wr_addr_i == ADDR_CSR_A);
        hit_b    = wr_en_i && (wr_addr_i == ADDR_CSR_B);
        hit_aux  = wr_en_i && (wr_addr_i == ADDR_AUX);
        reload_o = {hit_b | hit_aux, hit_a | hit_aux};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_a_o <= '0;
            csr_b_o <= '0;
            set_o   <= 1'b0;
        end else begin
            if (hit_a)   csr_a_o <= wr_data_i;
            if (hit_b)   csr_b_o <= wr_data_i;
            if (hit_aux) set_o   <= wr_data_i[AUX_SET_BIT];
        end
    end

    assert_csr_a_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_addr_i == ADDR_CSR_A) |=> $stable(csr_a_o));

    assert_csr_b_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_addr_i == ADDR_CSR_B) |=> $stable(csr_b_o));

    assert_set_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_addr_i == ADDR_AUX) |=> $stable(set_o));

    assert_ignored_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i != ADDR_CSR_A && wr_addr_i != ADDR_CSR_B &&
         wr_addr_i != ADDR_AUX) |-> (reload_o == 2'b00));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_sel_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] div_i,
    output logic             tick_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tick_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next state: load, count, wrap; restart overrides all
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TG_RELOAD: begin
                cnt_d   = div_i - ONE;
                state_d = TG_RUN;
            end
            TG_RUN: begin
                if (cnt_q == '0) cnt_d = div_i - ONE;
                else             cnt_d = cnt_q - ONE;
            end
        endcase
        if (reload_i) state_d = TG_RELOAD;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TG_RELOAD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        tick_o = (state_q == TG_RUN) && (cnt_q == '0);
    end

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TG_RUN) |-> (cnt_q < div_i));

    assert_quiet_after_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> !tick_o);

endmodule

// File: rtl/dual_set_baud_sel.sv
module dual_set_baud_sel
    import baud_sel_pkg::*;
#(
    parameter int unsigned REF_HZ = 3686400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       tick_rx_a,
    output logic       tick_tx_a,
    output logic       tick_rx_b,
    output logic       tick_tx_b
);

    localparam int unsigned MAX_DIV = rate_divisor(REF_HZ, 0);
    localparam int          CNT_W   = $clog2(MAX_DIV + 1);
    localparam int          N_CH    = 2;
    localparam int          N_GEN   = 2 * N_CH;

    logic [7:0]      csr_a, csr_b;
    logic            set_sel;
    logic [N_CH-1:0] reload;
    logic [N_GEN-1:0] tick;
    logic [7:0]      csr [N_CH];

    baud_sel_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .csr_a_o   (csr_a),
        .csr_b_o   (csr_b),
        .set_o     (set_sel),
        .reload_o  (reload)
    );

    assign csr[0] = csr_a;
    assign csr[1] = csr_b;

    // Generator order: rx A, tx A, rx B, tx B
    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        localparam int CH    = g / 2;
        localparam bit IS_RX = (g % 2) == 0;

        logic [3:0]       code;
        logic [CNT_W-1:0] div;

        if (IS_RX) begin : g_rx
            assign code = csr[CH][7:4];
        end else begin : g_tx
            assign code = csr[CH][3:0];
        end

        baud_div_lut #(.REF_HZ(REF_HZ), .CNT_W(CNT_W)) u_lut (
            .set_i  (set_sel),
            .code_i (code),
            .div_o  (div)
        );

        baud_tick_gen #(.CNT_W(CNT_W)) u_gen (
            .clk      (clk),
            .rst_n    (rst_n),
            .reload_i (reload[CH]),
            .div_i    (div),
            .tick_o   (tick[g])
        );
    end

    assign tick_rx_a = tick[0];
    assign tick_tx_a = tick[1];
    assign tick_rx_b = tick[2];
    assign tick_tx_b = tick[3];

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tick == '0));

endmodule

// File: tb/dual_set_baud_sel_bench.sv
module dual_set_baud_sel_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic tick_rx_a, tick_tx_a, tick_rx_b, tick_tx_b;
    logic [3:0] tv;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    longint cyc = 0;

    longint ref_t [4];
    longint div_e [4];
    bit aux_set = 0;
    logic [7:0] csr_m [2];

    dual_set_baud_sel u_dual_set_baud_sel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tick_rx_a(tick_rx_a), .tick_tx_a(tick_tx_a),
        .tick_rx_b(tick_rx_b), .tick_tx_b(tick_tx_b)
    );

    assign tv = {tick_tx_b, tick_rx_b, tick_tx_a, tick_rx_a};

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Expected divisor: round(3686400 / (16 * baud)), baud held as 2x
    function automatic longint exp_div(bit s, logic [3:0] c);
        longint b2;
        case ({s, c})
            5'd0: b2 = 100;   5'd1: b2 = 220;   5'd2: b2 = 269;   5'd3: b2 = 400;
            5'd4: b2 = 600;   5'd5: b2 = 1200;  5'd6: b2 = 2400;  5'd7: b2 = 2100;
            5'd8: b2 = 4800;  5'd9: b2 = 9600;  5'd10: b2 = 14400; 5'd11: b2 = 19200;
            5'd12: b2 = 76800;
            5'd16: b2 = 150;  5'd17: b2 = 220;  5'd18: b2 = 269;  5'd19: b2 = 300;
            5'd20: b2 = 600;  5'd21: b2 = 1200; 5'd22: b2 = 2400; 5'd23: b2 = 4000;
            5'd24: b2 = 4800; 5'd25: b2 = 9600; 5'd26: b2 = 3600; 5'd27: b2 = 19200;
            5'd28: b2 = 38400;
            default: b2 = 9600;
        endcase
        return (2 * 3686400 + 8 * b2) / (16 * b2);
    endfunction

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic refresh(int g);
        logic [3:0] c;
        c = (g % 2 == 0) ? csr_m[g/2][7:4] : csr_m[g/2][3:0];
        div_e[g] = exp_div(aux_set, c);
        ref_t[g] = cyc;
    endtask

    task automatic do_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            3'd0: begin csr_m[0] = d; refresh(0); refresh(1); end
            3'd1: begin csr_m[1] = d; refresh(2); refresh(3); end
            3'd4: begin aux_set = d[7]; for (int g = 0; g < 4; g++) refresh(g); end
            default: ;
        endcase
    endtask

    // Observe two ticks per output; compare against the phase model
    task automatic measure(string tag);
        longint now, lim;
        longint e1 [4];
        longint t1 [4];
        longint t2 [4];
        now = cyc;
        lim = 0;
        for (int g = 0; g < 4; g++) begin
            e1[g] = ref_t[g] + ((now - ref_t[g]) / div_e[g] + 1) * div_e[g];
            t1[g] = -1; t2[g] = -1;
            if (e1[g] + div_e[g] > lim) lim = e1[g] + div_e[g];
        end
        while (cyc < lim + 2) begin
            @(negedge clk);
            for (int g = 0; g < 4; g++) begin
                if (tv[g]) begin
                    if (t1[g] < 0) t1[g] = cyc;
                    else if (t2[g] < 0) t2[g] = cyc;
                end
            end
        end
        for (int g = 0; g < 4; g++) begin
            chk(t1[g] == e1[g], tag, $sformatf("first tick out%0d", g), t1[g] - now, e1[g] - now);
            chk(t2[g] - t1[g] == div_e[g], "R7", $sformatf("period out%0d (%s)", g, tag),
                t2[g] - t1[g], div_e[g]);
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        checks++;
        $display("FAIL R7 watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        csr_m[0] = '0; csr_m[1] = '0;
        repeat (5) @(negedge clk);
        chk(tv == 4'b0, "R1", "ticks in reset", tv, 0);
        rst_n = 1'b1;
        for (int g = 0; g < 4; g++) refresh(g);
        @(negedge clk);
        chk(tv == 4'b0, "R1", "ticks after release", tv, 0);
        measure("R1");

        // Sweep both sets and every code; nibbles differ per output (R2)
        for (int s = 0; s < 2; s++) begin
            do_write(3'd4, (s == 1) ? 8'h95 : 8'h2A);   // noise bits beside bit 7 (R3)
            measure("R9 R3");
            for (int c = 0; c < 16; c++) begin
                logic [3:0] cc, cx;
                string tag;
                cc = 4'(c);
                cx = cc ^ 4'h1;
                do_write(3'd0, {cc, cx});
                do_write(3'd1, {cx, cc});
                if (c >= 13)    tag = "R2 R6";
                else if (s == 0) tag = "R2 R4";
                else            tag = "R2 R5";
                measure(tag);
            end
        end

        // Channel isolation: B keeps phase across an A write
        do_write(3'd1, 8'hCC);
        repeat (7) @(negedge clk);
        do_write(3'd0, 8'h9C);
        measure("R8");

        // Writes to unused addresses: no restart, no change
        do_write(3'd2, 8'hFF);
        do_write(3'd3, 8'h00);
        do_write(3'd5, 8'h12);
        do_write(3'd6, 8'h80);
        do_write(3'd7, 8'h11);
        measure("R10");

        report();
    end

endmodule